// File: doc/BRIEF.md
# Associative Sparse Column Accumulator

This block builds one column of a sparse matrix product. It takes a stream of partial products. Each partial product carries a row index and two 10-bit unsigned operands. A small associative index array holds the row index of every nonzero entry collected so far, and a companion value store holds each entry's running sum in the same slot. Each accepted input is compared against every stored index in the cycle it is presented. A match makes the block multiply the operands and add the product into that slot's value. A miss makes a slot sequencer hand out the next free slot, and the saturated product becomes the new entry's value.

Once a column is complete, a drain command walks the valid slots in slot order and emits one (row, value) pair per cycle, marking the final pair. A clear pulse empties the unit in one cycle so that the next column can start. Inputs use a valid/ready handshake. Ready drops only while the unit is draining, while a clear or drain command is present, or when a miss would need a slot and none is left.

Top module: `sparse_col_merge`

## Requirements
- R1: After reset the unit is empty: full is 0, out_valid is 0, in_ready is 1 with no command present, and a drain command on the empty unit produces no output.
- R2: An accepted input whose row index matches no stored entry takes the lowest slot not yet handed out (slots are handed out 0, 1, 2, ... in order). Its value is the product of the two operands.
- R3: An accepted input whose row index matches a stored entry leaves the entry count unchanged and replaces that entry's value with the stored value plus the product of the operands. At most one slot ever matches a given index.
- R4: Values are 10-bit unsigned. Any product, and any sum of a product and a stored value, above 1023 is stored as 1023.
- R5: Inputs accepted in consecutive cycles with the same row index all accumulate into one entry. This holds when the first of them created the entry.
- R6: full is 1 exactly when all 16 slots are in use. While full, an input whose index misses holds in_ready at 0 and is not taken, and an input whose index hits is still accepted.
- R7: A clear pulse empties the unit in one cycle. The next cycle shows full at 0, a following drain emits nothing, and the next new index goes to slot 0.
- R8: A drain command on a non-empty unit emits the entries starting on the cycle after the command, one per cycle in slot order, with out_last high only on the final pair. in_ready is 0 throughout.
- R9: Draining does not alter the stored entries, so a second drain emits the same pairs.
- R10: in_ready is 0 in any cycle in which clr or drain_start is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Empty all slots (one-cycle pulse) |
| in_valid | input | 1 | Partial product present |
| in_ready | output | 1 | Partial product will be taken this cycle |
| in_row | input | 10 | Row index of the partial product |
| in_a | input | 10 | First multiplicand |
| in_b | input | 10 | Second multiplicand |
| drain_start | input | 1 | Start emitting the column |
| out_valid | output | 1 | Output pair present |
| out_row | output | 10 | Row index of the output pair |
| out_val | output | 10 | Accumulated value of the output pair |
| out_last | output | 1 | Final pair of the drain |
| full | output | 1 | All slots in use |

## Verification
The assertions assume that clr and drain_start are short pulses and that a drain command is not reissued while a drain is already running. The bench honours this by raising each command for a single cycle at the falling edge and waiting for out_valid to fall before it issues the next command. The assertions also rely on the uniqueness of stored indices, which holds only if the sequencer is the sole way that slots get filled. The bench therefore drives all traffic through the handshake and never presents an input during a command cycle. It does, however, deliberately present repeated indices back to back so that the forwarding path is exercised.

// File: rtl/scm_pkg.sv
package scm_pkg;
  localparam int unsigned SCM_SLOTS = 16;
  localparam int unsigned SCM_IDX_W = 10;
  localparam int unsigned SCM_VAL_W = 10;

  // Kind of write-back pending in the commit stage
  typedef enum logic [1:0] {
    WB_IDLE   = 2'd0,
    WB_UPDATE = 2'd1,
    WB_ALLOC  = 2'd2
  } wb_kind_e;
endpackage

// File: rtl/cam_index_array.sv
module cam_index_array #(
  parameter int unsigned SLOTS  = 16,
  parameter int unsigned IDX_W  = 10,
  parameter int unsigned SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic [IDX_W-1:0]  wr_row,
  input  logic [IDX_W-1:0]  key,
  input  logic [SLOT_W-1:0] rd_slot,
  output logic [SLOTS-1:0]  match,
  output logic [IDX_W-1:0]  rd_row
);
  logic [IDX_W-1:0] row_q [SLOTS];
  logic [SLOTS-1:0] vld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int i = 0; i < int'(SLOTS); i++) row_q[i] <= '0;
    end else begin
      for (int i = 0; i < int'(SLOTS); i++) begin
        if (wr_en && wr_slot == SLOT_W'(i)) row_q[i] <= wr_row;
      end
      if (clr) vld_q <= '0;
      else if (wr_en) vld_q[wr_slot] <= 1'b1;
    end
  end

  // One comparator per slot, all evaluated in the same cycle
  for (genvar g = 0; g < int'(SLOTS); g++) begin : g_cmp
    assign match[g] = vld_q[g] && (row_q[g] == key);
  end

  assign rd_row = row_q[rd_slot];
endmodule

// File: rtl/value_store.sv
module value_store #(
  parameter int unsigned SLOTS  = 16,
  parameter int unsigned VAL_W  = 10,
  parameter int unsigned SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic [VAL_W-1:0]  wr_val,
  input  logic [SLOT_W-1:0] rd_a_slot,
  output logic [VAL_W-1:0]  rd_a,
  input  logic [SLOT_W-1:0] rd_b_slot,
  output logic [VAL_W-1:0]  rd_b
);
  logic [VAL_W-1:0] mem_q [SLOTS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(SLOTS); i++) mem_q[i] <= '0;
    end else if (wr_en) begin
      mem_q[wr_slot] <= wr_val;
    end
  end

  assign rd_a = mem_q[rd_a_slot];
  assign rd_b = mem_q[rd_b_slot];
endmodule

// File: rtl/slot_sequencer.sv
module slot_sequencer #(
  parameter int unsigned SLOTS  = 16,
  parameter int unsigned SLOT_W = $clog2(SLOTS),
  parameter int unsigned CNT_W  = $clog2(SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              alloc,
  output logic [CNT_W-1:0]  fill_cnt,
  output logic [SLOT_W-1:0] alloc_slot,
  output logic              full
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (clr)              cnt_q <= '0;
    else if (alloc && !full)   cnt_q <= cnt_q + CNT_W'(1);
  end

  assign fill_cnt   = cnt_q;
  assign alloc_slot = cnt_q[SLOT_W-1:0];
  assign full       = (cnt_q == CNT_W'(SLOTS));
endmodule

// File: rtl/drain_walker.sv
module drain_walker #(
  parameter int unsigned SLOTS  = 16,
  parameter int unsigned SLOT_W = $clog2(SLOTS),
  parameter int unsigned CNT_W  = $clog2(SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              start,
  input  logic [CNT_W-1:0]  fill_cnt,
  output logic              active,
  output logic [SLOT_W-1:0] ptr,
  output logic              last
);
  logic              act_q;
  logic [SLOT_W-1:0] ptr_q;

  assign last = act_q && ((CNT_W'(ptr_q) + CNT_W'(1)) == fill_cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      ptr_q <= '0;
    end else if (clr) begin
      act_q <= 1'b0;
      ptr_q <= '0;
    end else if (start && !act_q && fill_cnt != '0) begin
      act_q <= 1'b1;
      ptr_q <= '0;
    end else if (act_q) begin
      if (last) act_q <= 1'b0;
      else      ptr_q <= ptr_q + SLOT_W'(1);
    end
  end

  assign active = act_q;
  assign ptr    = ptr_q;
endmodule

// File: rtl/sparse_col_merge.sv
module sparse_col_merge
  import scm_pkg::*;
#(
  parameter int unsigned SLOTS = SCM_SLOTS,
  parameter int unsigned IDX_W = SCM_IDX_W,
  parameter int unsigned VAL_W = SCM_VAL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [IDX_W-1:0] in_row,
  input  logic [VAL_W-1:0] in_a,
  input  logic [VAL_W-1:0] in_b,
  input  logic             drain_start,
  output logic             out_valid,
  output logic [IDX_W-1:0] out_row,
  output logic [VAL_W-1:0] out_val,
  output logic             out_last,
  output logic             full
);
  localparam int unsigned SLOT_W = $clog2(SLOTS);
  localparam int unsigned CNT_W  = $clog2(SLOTS + 1);
  localparam int unsigned PROD_W = 2 * VAL_W + 1;
  localparam logic [VAL_W-1:0] VAL_MAX = '1;

  // Saturating multiply-add
  function automatic logic [VAL_W-1:0] sat_mac(input logic [VAL_W-1:0] base,
                                               input logic [VAL_W-1:0] a,
                                               input logic [VAL_W-1:0] b);
    logic [PROD_W-1:0] s;
    s = PROD_W'(a) * PROD_W'(b) + PROD_W'(base);
    return (s > PROD_W'(VAL_MAX)) ? VAL_MAX : s[VAL_W-1:0];
  endfunction

  // Lowest set bit wins
  function automatic logic [SLOT_W-1:0] first_set(input logic [SLOTS-1:0] v);
    logic [SLOT_W-1:0] r;
    r = '0;
    for (int i = int'(SLOTS) - 1; i >= 0; i--) begin
      if (v[i]) r = SLOT_W'(i);
    end
    return r;
  endfunction

  // Commit stage registers
  wb_kind_e          wb_kind;
  logic [SLOT_W-1:0] wb_slot;
  logic [IDX_W-1:0]  wb_row;
  logic [VAL_W-1:0]  wb_val;
  logic              wb_pend;

  // Named internal events
  logic [SLOTS-1:0]  cam_match;
  logic [SLOTS-1:0]  fwd_vec;
  logic [SLOTS-1:0]  match_vec;
  logic              hit;
  logic [SLOT_W-1:0] hit_slot;
  logic [VAL_W-1:0]  stored_val;
  logic [VAL_W-1:0]  old_val;
  logic [VAL_W-1:0]  new_val;
  logic              accept;
  logic              alloc;
  logic [CNT_W-1:0]  fill_cnt;
  logic [SLOT_W-1:0] alloc_slot;
  logic              draining;
  logic [SLOT_W-1:0] drain_ptr;
  logic              drain_last;

  assign wb_pend = (wb_kind != WB_IDLE);

  cam_index_array #(.SLOTS(SLOTS), .IDX_W(IDX_W), .SLOT_W(SLOT_W)) u_cam (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr),
    .wr_en   (wb_pend),
    .wr_slot (wb_slot),
    .wr_row  (wb_row),
    .key     (in_row),
    .rd_slot (drain_ptr),
    .match   (cam_match),
    .rd_row  (out_row)
  );

  value_store #(.SLOTS(SLOTS), .VAL_W(VAL_W), .SLOT_W(SLOT_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wb_pend),
    .wr_slot   (wb_slot),
    .wr_val    (wb_val),
    .rd_a_slot (hit_slot),
    .rd_a      (stored_val),
    .rd_b_slot (drain_ptr),
    .rd_b      (out_val)
  );

  slot_sequencer #(.SLOTS(SLOTS), .SLOT_W(SLOT_W), .CNT_W(CNT_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (clr),
    .alloc      (alloc),
    .fill_cnt   (fill_cnt),
    .alloc_slot (alloc_slot),
    .full       (full)
  );

  drain_walker #(.SLOTS(SLOTS), .SLOT_W(SLOT_W), .CNT_W(CNT_W)) u_drain (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .start    (drain_start),
    .fill_cnt (fill_cnt),
    .active   (draining),
    .ptr      (drain_ptr),
    .last     (drain_last)
  );

  // Forward the entry still in the commit stage, both its index and its value
  assign fwd_vec   = (wb_pend && wb_row == in_row) ? (SLOTS'(1) << wb_slot) : '0;
  assign match_vec = cam_match | fwd_vec;
  assign hit       = |match_vec;
  assign hit_slot  = first_set(match_vec);
  assign old_val   = (wb_pend && wb_slot == hit_slot) ? wb_val : stored_val;
  assign new_val   = sat_mac(hit ? old_val : '0, in_a, in_b);

  assign in_ready  = !draining && !clr && !drain_start && (hit || !full);
  assign accept    = in_valid && in_ready;
  assign alloc     = accept && !hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_kind <= WB_IDLE;
      wb_slot <= '0;
      wb_row  <= '0;
      wb_val  <= '0;
    end else if (accept) begin
      wb_kind <= hit ? WB_UPDATE : WB_ALLOC;
      wb_slot <= hit ? hit_slot : alloc_slot;
      wb_row  <= in_row;
      wb_val  <= new_val;
    end else begin
      wb_kind <= WB_IDLE;
    end
  end

  assign out_valid = draining;
  assign out_last  = drain_last;
endmodule

// File: rtl/sparse_col_merge_chk.sv
module sparse_col_merge_chk #(
  parameter int unsigned SLOTS = 16,
  parameter int unsigned CNT_W = $clog2(SLOTS + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_last,
  input logic             full,
  input logic             hit,
  input logic             accept,
  input logic [SLOTS-1:0] match_vec,
  input logic [CNT_W-1:0] fill_cnt
);
  assert_single_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_vec));

  assert_alloc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !hit) |=> fill_cnt == $past(fill_cnt) + CNT_W'(1));

  assert_hit_keeps_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && hit && !clr) |=> $stable(fill_cnt));

  assert_full_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !hit) |-> !in_ready);

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fill_cnt <= CNT_W'(SLOTS));

  assert_clear_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (fill_cnt == '0 && !out_valid && !full));

  assert_drain_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  assert_last_in_drain_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);

  assert_last_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |=> !out_valid);

  assert_cmd_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |-> !in_ready);
endmodule

bind sparse_col_merge sparse_col_merge_chk #(.SLOTS(SLOTS), .CNT_W($clog2(SLOTS + 1))) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .clr       (clr),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_last  (out_last),
  .full      (full),
  .hit       (hit),
  .accept    (accept),
  .match_vec (match_vec),
  .fill_cnt  (fill_cnt)
);

// File: tb/sparse_col_merge_tb.sv
module sparse_col_merge_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clr = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [9:0] in_row = '0;
  logic [9:0] in_a = '0;
  logic [9:0] in_b = '0;
  logic       drain_start = 1'b0;
  logic       out_valid;
  logic [9:0] out_row;
  logic [9:0] out_val;
  logic       out_last;
  logic       full;

  int checks = 0;
  int fails  = 0;

  // Reference model of the stored column
  int mrow [16];
  int mval [16];
  int mn = 0;

  always #10 clk = ~clk;

  sparse_col_merge u_dut (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_row(in_row), .in_a(in_a), .in_b(in_b),
    .drain_start(drain_start),
    .out_valid(out_valid), .out_row(out_row), .out_val(out_val),
    .out_last(out_last), .full(full)
  );

  // Stimulus table: {row, a, b}
  localparam int NV = 20;
  localparam logic [29:0] VEC [NV] = '{
    {10'd5,    10'd3,  10'd4},  {10'd5,   10'd2,  10'd2},
    {10'd9,    10'd1,  10'd1},  {10'd700, 10'd10, 10'd10},
    {10'd5,    10'd1,  10'd1},  {10'd9,   10'd40, 10'd30},
    {10'd9,    10'd1,  10'd1},  {10'd1023,10'd0,  10'd7},
    {10'd0,    10'd31, 10'd33}, {10'd42,  10'd5,  10'd5},
    {10'd42,   10'd5,  10'd5},  {10'd42,  10'd5,  10'd5},
    {10'd700,  10'd1,  10'd1},  {10'd300, 10'd2,  10'd3},
    {10'd1023, 10'd2,  10'd2},  {10'd301, 10'd1,  10'd0},
    {10'd5,    10'd0,  10'd0},  {10'd0,   10'd0,  10'd0},
    {10'd777,  10'd32, 10'd31}, {10'd777, 10'd1,  10'd31}
  };

  function automatic int ref_sum(int base, int a, int b);
    int t;
    t = base + a * b;
    if (t > 1023) t = 1023;
    return t;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic model_take(input int r, input int a, input int b);
    int found;
    found = -1;
    for (int i = 0; i < mn; i++) if (mrow[i] == r) found = i;
    if (found >= 0) mval[found] = ref_sum(mval[found], a, b);
    else begin
      mrow[mn] = r;
      mval[mn] = ref_sum(0, a, b);
      mn++;
    end
  endtask

  // Present one input at the falling edge; accepted at the next rising edge
  task automatic put(input int r, input int a, input int b, input string req);
    @(negedge clk);
    in_valid = 1'b1;
    in_row = 10'(r); in_a = 10'(a); in_b = 10'(b);
    #1;
    check(in_ready === 1'b1, req, int'(in_ready), 1);
    @(posedge clk);
    model_take(r, a, b);
  endtask

  task automatic go_idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain_and_check(input string req);
    @(negedge clk);
    in_valid = 1'b0;
    drain_start = 1'b1;
    #1;
    check(in_ready === 1'b0, "R10 ready low with drain_start", int'(in_ready), 0);
    @(negedge clk);
    drain_start = 1'b0;
    for (int i = 0; i < mn; i++) begin
      check(out_valid === 1'b1, req, int'(out_valid), 1);
      check(out_row == 10'(mrow[i]), req, int'(out_row), mrow[i]);
      check(out_val == 10'(mval[i]), req, int'(out_val), mval[i]);
      check(out_last === (i == mn - 1), "R8 last flag", int'(out_last), int'(i == mn - 1));
      check(in_ready === 1'b0, "R8 ready low while draining", int'(in_ready), 0);
      @(negedge clk);
    end
    check(out_valid === 1'b0, "R8 drain ends", int'(out_valid), 0);
  endtask

  task automatic pulse_clear();
    @(negedge clk);
    in_valid = 1'b0;
    clr = 1'b1;
    #1;
    check(in_ready === 1'b0, "R10 ready low with clr", int'(in_ready), 0);
    @(negedge clk);
    clr = 1'b0;
    mn = 0;
    check(full === 1'b0, "R7 full after clear", int'(full), 0);
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(full === 1'b0, "R1 full after reset", int'(full), 0);
    check(out_valid === 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
    check(in_ready === 1'b1, "R1 ready after reset", int'(in_ready), 1);
    drain_and_check("R1 empty drain");
    @(negedge clk);
    check(out_valid === 1'b0, "R1 empty drain stays silent", int'(out_valid), 0);

    // Table walk: R2 allocation order, R3 accumulate, R4 saturation, R5 back-to-back
    for (int v = 0; v < NV; v++)
      put(int'(VEC[v][29:20]), int'(VEC[v][19:10]), int'(VEC[v][9:0]), "R5 accept");
    go_idle();
    drain_and_check("R2 R3 R4 R5 column contents");
    // R9 second drain sees the same data
    drain_and_check("R9 contents kept after drain");

    // R7 clear, then R6 fill to capacity
    pulse_clear();
    drain_and_check("R7 empty after clear");
    for (int s = 0; s < 16; s++) put(100 + s, 1, s, "R6 fill");
    @(negedge clk);
    in_valid = 1'b1; in_row = 10'd999; in_a = 10'd1; in_b = 10'd1;
    #1;
    check(full === 1'b1, "R6 full at 16", int'(full), 1);
    for (int k = 0; k < 3; k++) begin
      check(in_ready === 1'b0, "R6 miss stalls while full", int'(in_ready), 0);
      @(negedge clk);
      #1;
    end
    in_row = 10'd103; in_a = 10'd4; in_b = 10'd5;
    #1;
    check(in_ready === 1'b1, "R6 hit accepted while full", int'(in_ready), 1);
    @(posedge clk);
    model_take(103, 4, 5);
    go_idle();
    drain_and_check("R6 stalled miss not taken");

    // R7 new column restarts at slot 0
    pulse_clear();
    put(55, 6, 7, "R7 accept after clear");
    put(55, 1, 1, "R5 accept");
    go_idle();
    drain_and_check("R7 restart at slot 0");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule